// File: doc/BRIEF.md
# Two-Level Segment/Page Address Translator

This block turns a 24-bit logical address into a 32-bit physical address. The logical address has three fields: a segment number, a page index inside that segment, and a byte offset inside the page. The block first reads the descriptor of the segment from a segment table in memory. That descriptor gives the segment's access rights, how many pages the segment has, and the base of a page table that belongs only to that segment. The block checks the request against the descriptor. If the request passes, the block reads the page entry for the page index and joins the frame number with the offset. If the request fails, the block stops after the descriptor read and reports a fault code.

Requests arrive on a valid/ready handshake that carries the address and a write flag. The block handles one translation at a time. Both table reads go through a single memory read port with a grant and a variable response latency. The result is held until the consumer takes it. A static input supplies the segment table base.

Top module: `segpg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_req` is 0. A request is accepted only while the block is idle, and `req_ready` drops in the cycle after an accept.
- R2: The first memory read of a translation is at `seg_tbl_base + 8*s`. If the segment passes its checks, the second read is at `pt_base + 8*p`. The field positions are: logical address bits [23:20] = s, [19:12] = p, [11:0] = d.
- R3: On success, `rsp_fault` is 0 and `rsp_paddr` = {frame, d}. Page entry layout: bit 0 = present, bits [20:1] = frame, bits [63:21] reserved.
- R4: Segment descriptor layout: bit 0 = present, bit 1 = read allowed, bit 2 = write allowed, bits [11:3] = page count, bits [43:12] = page-table base, bits [63:44] reserved. A descriptor with bit 0 clear, or with any reserved bit set, gives fault 3 (not present). This fault takes priority over every other check.
- R5: A write to a segment without write permission, or a read from a segment without read permission, gives fault 2 (permission). This check takes priority over the bounds check.
- R6: A page index p ≥ page count gives fault 1 (bounds). A page count of 0 rejects every page, and a count of 256 accepts every page.
- R7: A segment fault (R4, R5, R6) ends the walk after one memory read. No page entry is read.
- R8: A page entry with bit 0 clear, or with any reserved bit set, gives fault 3 after two reads.
- R9: Whenever `rsp_fault` is non-zero, `rsp_paddr` is 0.
- R10: `rsp_valid`, `rsp_paddr` and `rsp_fault` stay unchanged until `rsp_ready` is 1. No new request is accepted while a result is pending.
- R11: `mem_rd_req` and `mem_rd_addr` stay unchanged until `mem_rd_gnt` is 1. Each read waits for its own `mem_rd_rvalid`, whatever the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_tbl_base | input | 32 | Byte address of segment table entry 0 |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_vaddr | input | 24 | Logical address {s, p, d} |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 bounds, 2 permission, 3 not present |
| mem_rd_req | output | 1 | Table read request |
| mem_rd_gnt | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_rvalid | input | 1 | Read data returned |
| mem_rd_rdata | input | 64 | Returned table entry |

## Verification
Several internal faults show up at the ports within the current translation. A wrong walk state or a lost descriptor value shows up as a wrong second read address. A missing or extra page read changes the read count. A wrong offset join changes the physical address at the response. Each of these is visible at the end of that same translation. The bench sweeps every segment against every page index under changing grant stalls and read latencies, so an error in check priority or bounds comparison shows up as a wrong fault code on the first address that hits it.

// File: rtl/segpg_pkg.sv
// segpg_pkg: shared widths, entry layouts and fault codes for the translator.
// Assumes table entries are one memory word each and entries are packed
// back to back, so an entry index scales by ENT_BYTES.
package segpg_pkg;
    parameter int SEG_W     = 4;
    parameter int PG_W      = 8;
    parameter int OFF_W     = 12;
    parameter int FRM_W     = 20;
    parameter int PA_W      = 32;
    parameter int WORD_W    = 64;
    parameter int ENT_BYTES = 8;

    localparam int LA_W   = SEG_W + PG_W + OFF_W;
    localparam int CNT_W  = PG_W + 1;
    localparam int DESC_W = PA_W + CNT_W + 3;
    localparam int PTE_W  = FRM_W + 1;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_BOUNDS = 2'd1,
        FLT_PERM   = 2'd2,
        FLT_ABSENT = 2'd3
    } fault_e;

    typedef struct packed {
        logic [PA_W-1:0]  pt_base;
        logic [CNT_W-1:0] pg_cnt;
        logic             wr_ok;
        logic             rd_ok;
        logic             vld;
    } seg_desc_t;

    typedef struct packed {
        logic [FRM_W-1:0] frame;
        logic             vld;
    } pte_t;
endpackage

// File: rtl/segpg_entry_addr.sv
// segpg_entry_addr: byte address of entry IDX inside a table at BASE.
// Assumes ENT_BYTES is a power of two; the address wraps on overflow.
module segpg_entry_addr #(
    parameter int IDX_W     = 4,
    parameter int ADDR_W    = 32,
    parameter int ENT_BYTES = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int SHIFT = $clog2(ENT_BYTES);

    // scale the index by the entry size and add the base
    always_comb addr = base + (ADDR_W'(idx) << SHIFT);
endmodule

// File: rtl/segpg_seg_check.sv
// segpg_seg_check: decodes a segment descriptor word and checks it against
// the request. Checks in priority order: present, permission, page bounds.
// Assumes any set reserved bit means the entry is malformed (not present).
module segpg_seg_check
    import segpg_pkg::*;
(
    input  logic [WORD_W-1:0] entry,
    input  logic [PG_W-1:0]   page,
    input  logic              write,
    output fault_e            fault,
    output logic [PA_W-1:0]   pt_base
);
    seg_desc_t desc;
    logic      rsvd_set;

    // split the word into descriptor fields and reserved bits
    always_comb begin
        desc     = seg_desc_t'(entry[DESC_W-1:0]);
        rsvd_set = |entry[WORD_W-1:DESC_W];
        pt_base  = desc.pt_base;
    end

    // pick the highest-priority fault
    always_comb begin
        if (!desc.vld || rsvd_set)
            fault = FLT_ABSENT;
        else if (write ? !desc.wr_ok : !desc.rd_ok)
            fault = FLT_PERM;
        else if ({1'b0, page} >= desc.pg_cnt)
            fault = FLT_BOUNDS;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/segpg_pte_decode.sv
// segpg_pte_decode: splits a page entry word into present flag and frame.
// Assumes any set reserved bit means the entry is not present.
module segpg_pte_decode
    import segpg_pkg::*;
(
    input  logic [WORD_W-1:0] entry,
    output logic              present,
    output logic [FRM_W-1:0]  frame
);
    pte_t pte;

    // field split and present qualification
    always_comb begin
        pte     = pte_t'(entry[PTE_W-1:0]);
        present = pte.vld && !(|entry[WORD_W-1:PTE_W]);
        frame   = pte.frame;
    end
endmodule

// File: rtl/segpg_xlate.sv
// segpg_xlate: one-at-a-time translator. Reads the segment descriptor, checks
// it, then reads the page entry and forms {frame, offset}. The result is held
// until it is taken.
// Assumes seg_tbl_base is static while a walk runs, and assumes the memory
// returns exactly one rvalid per granted read.
module segpg_xlate
    import segpg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PA_W-1:0]     seg_tbl_base,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LA_W-1:0]     req_vaddr,
    input  logic                req_write,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [PA_W-1:0]     rsp_paddr,
    output logic [1:0]          rsp_fault,
    output logic                mem_rd_req,
    input  logic                mem_rd_gnt,
    output logic [PA_W-1:0]     mem_rd_addr,
    input  logic                mem_rd_rvalid,
    input  logic [WORD_W-1:0]   mem_rd_rdata
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_SEG_RD, ST_SEG_WT, ST_PTE_RD, ST_PTE_WT, ST_DONE
    } state_e;

    state_e           state_q;
    logic [LA_W-1:0]  vaddr_q;
    logic             write_q;
    logic [PA_W-1:0]  ptbase_q;
    logic [PA_W-1:0]  paddr_q;
    fault_e           fault_q;

    logic [SEG_W-1:0] f_seg;
    logic [PG_W-1:0]  f_page;
    logic [OFF_W-1:0] f_off;
    logic [PA_W-1:0]  seg_addr, pte_addr, desc_ptbase;
    fault_e           seg_fault;
    logic             pte_present;
    logic [FRM_W-1:0] pte_frame;

    // split the held logical address into its three fields
    always_comb begin
        f_seg  = vaddr_q[LA_W-1 -: SEG_W];
        f_page = vaddr_q[OFF_W +: PG_W];
        f_off  = vaddr_q[OFF_W-1:0];
    end

    segpg_entry_addr #(.IDX_W(SEG_W), .ADDR_W(PA_W), .ENT_BYTES(ENT_BYTES)) i_seg_addr (
        .base(seg_tbl_base), .idx(f_seg), .addr(seg_addr)
    );

    segpg_entry_addr #(.IDX_W(PG_W), .ADDR_W(PA_W), .ENT_BYTES(ENT_BYTES)) i_pte_addr (
        .base(ptbase_q), .idx(f_page), .addr(pte_addr)
    );

    segpg_seg_check i_seg_check (
        .entry(mem_rd_rdata), .page(f_page), .write(write_q),
        .fault(seg_fault), .pt_base(desc_ptbase)
    );

    segpg_pte_decode i_pte_decode (
        .entry(mem_rd_rdata), .present(pte_present), .frame(pte_frame)
    );

    // handshake and memory port outputs from the walk state
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        rsp_valid   = (state_q == ST_DONE);
        rsp_paddr   = paddr_q;
        rsp_fault   = fault_q;
        mem_rd_req  = (state_q == ST_SEG_RD) || (state_q == ST_PTE_RD);
        mem_rd_addr = (state_q == ST_PTE_RD) ? pte_addr : seg_addr;
    end

    // walk sequencer: accept, descriptor read, page read, hold result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            vaddr_q  <= '0;
            write_q  <= 1'b0;
            ptbase_q <= '0;
            paddr_q  <= '0;
            fault_q  <= FLT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    write_q <= req_write;
                    state_q <= ST_SEG_RD;
                end
                ST_SEG_RD: if (mem_rd_gnt) state_q <= ST_SEG_WT;
                ST_SEG_WT: if (mem_rd_rvalid) begin
                    if (seg_fault != FLT_NONE) begin
                        fault_q <= seg_fault;
                        paddr_q <= '0;
                        state_q <= ST_DONE;
                    end else begin
                        ptbase_q <= desc_ptbase;
                        state_q  <= ST_PTE_RD;
                    end
                end
                ST_PTE_RD: if (mem_rd_gnt) state_q <= ST_PTE_WT;
                ST_PTE_WT: if (mem_rd_rvalid) begin
                    fault_q <= pte_present ? FLT_NONE : FLT_ABSENT;
                    paddr_q <= pte_present ? {pte_frame, f_off} : '0;
                    state_q <= ST_DONE;
                end
                ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // an accept closes the request window at once
    p_accept_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // a pending result is frozen until taken
    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

    // no new request while a result waits
    p_busy_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // memory read request held with a stable address until granted
    p_mem_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_gnt |=> mem_rd_req && $stable(mem_rd_addr));

    // a faulted result never carries an address
    p_fault_zero_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != 2'd0) |-> rsp_paddr == '0);
endmodule

// File: tb/test_segpg_xlate.sv
// test_segpg_xlate: sweeps every segment against every page index. Expected
// results come from arithmetic table contents held in a memory model.
module test_segpg_xlate;
    localparam logic [31:0] SEG_BASE = 32'h0000_1000;
    localparam logic [31:0] PT_REGION = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] seg_tbl_base = SEG_BASE;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_rd_req;
    logic        mem_rd_gnt = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_rvalid = 1'b0;
    logic [63:0] mem_rd_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int rd_total = 0;
    int rd_cnt = 0;
    logic [31:0] rd_addr [0:3];
    int n_tr = 0;

    always #4 clk = ~clk;

    segpg_xlate i_segpg_xlate (
        .clk(clk), .rst_n(rst_n), .seg_tbl_base(seg_tbl_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_rd_req(mem_rd_req),
        .mem_rd_gnt(mem_rd_gnt), .mem_rd_addr(mem_rd_addr),
        .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_rdata(mem_rd_rdata)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h (tr %0d)", tag, act, exp, n_tr);
        end
    endtask

    // arithmetic table contents
    function automatic logic [8:0] seg_cnt(input int s);
        if (s == 0) return 9'd256;
        if (s == 1) return 9'd0;
        return 9'(s * 16 + 3);
    endfunction
    function automatic logic [31:0] seg_ptb(input int s);
        return PT_REGION + 32'(s) * 32'h1000;
    endfunction
    function automatic logic [19:0] frm(input int s, input int p);
        return 20'(s * 4099 + p * 37 + 5);
    endfunction
    function automatic logic [63:0] desc_word(input int s);
        logic [63:0] w = '0;
        w[0] = (s != 15);
        w[1] = (s != 13);
        w[2] = ((s % 3) != 0);
        w[11:3] = seg_cnt(s);
        w[43:12] = seg_ptb(s);
        if (s == 14) w[50] = 1'b1;
        return w;
    endfunction
    function automatic logic [63:0] pte_word(input int s, input int p);
        logic [63:0] w = '0;
        w[0] = (((p ^ s) & 7) != 7);
        w[20:1] = frm(s, p);
        if (p == 200) w[33] = 1'b1;
        return w;
    endfunction
    function automatic logic [63:0] mem_model(input logic [31:0] a);
        if (a >= SEG_BASE && a < SEG_BASE + 32'd128)
            return desc_word(int'((a - SEG_BASE) >> 3));
        if (a >= PT_REGION && a < PT_REGION + 32'h1_0000 && ((a >> 3) & 32'h1FF) < 32'd256)
            return pte_word(int'((a - PT_REGION) >> 12), int'((a >> 3) & 32'h1FF));
        return '0;
    endfunction

    // memory model: grant stalls of 0..2 cycles, read latency of 0..3 cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_req && rst_n) begin
                logic [31:0] a0;
                a0 = mem_rd_addr;
                for (int k = 0; k < rd_total % 3; k++) begin
                    @(negedge clk);
                    chk(mem_rd_req && mem_rd_addr == a0, "R11 held request", 64'(mem_rd_addr), 64'(a0));
                end
                mem_rd_gnt = 1'b1;
                if (rd_cnt < 4) rd_addr[rd_cnt] = mem_rd_addr;
                rd_cnt++;
                @(negedge clk);
                mem_rd_gnt = 1'b0;
                for (int k = 0; k < rd_total % 4; k++) @(negedge clk);
                rd_total++;
                mem_rd_rvalid = 1'b1;
                mem_rd_rdata = mem_model(rd_addr[(rd_cnt - 1) & 3]);
                @(negedge clk);
                mem_rd_rvalid = 1'b0;
                mem_rd_rdata = '0;
            end
        end
    end

    task automatic translate(input int s, input int p, input logic w);
        logic [11:0] d;
        logic [1:0]  ef;
        logic [31:0] ea;
        int          ereads;
        logic [31:0] hold_a;
        logic [1:0]  hold_f;
        d = 12'(s * 291 + p * 13 + (w ? 7 : 0));
        // expected result from the requirements
        if (s == 15 || s == 14) ef = 2'd3;
        else if (w ? ((s % 3) == 0) : (s == 13)) ef = 2'd2;
        else if (9'(p) >= seg_cnt(s)) ef = 2'd1;
        else if ((((p ^ s) & 7) == 7) || p == 200) ef = 2'd3;
        else ef = 2'd0;
        ereads = (ef != 2'd0 && !((((p ^ s) & 7) == 7 || p == 200) && ef == 2'd3 && s != 14 && s != 15)) ? 1 : 2;
        ea = (ef == 2'd0) ? {frm(s, p), d} : 32'd0;

        n_tr++;
        rd_cnt = 0;
        chk(req_ready == 1'b1, "R1 idle before request", 64'(req_ready), 64'd1);
        req_vaddr = {4'(s), 8'(p), d};
        req_write = w;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1 busy after accept", 64'(req_ready), 64'd0);
        while (!rsp_valid) @(negedge clk);
        chk(rsp_fault == ef, (ef == 2'd2) ? "R5 fault code" : (ef == 2'd1) ? "R6 fault code" :
            (ef == 2'd3) ? "R4/R8 fault code" : "R3 fault code", 64'(rsp_fault), 64'(ef));
        chk(rsp_paddr == ea, (ef == 2'd0) ? "R3 physical address" : "R9 zero address", 64'(rsp_paddr), 64'(ea));
        chk(rd_cnt == ereads, "R7 read count", 64'(rd_cnt), 64'(ereads));
        chk(rd_addr[0] == SEG_BASE + 32'(s) * 8, "R2 descriptor address", 64'(rd_addr[0]), 64'(SEG_BASE + 32'(s) * 8));
        if (ereads == 2)
            chk(rd_addr[1] == seg_ptb(s) + 32'(p) * 8, "R2 page entry address", 64'(rd_addr[1]), 64'(seg_ptb(s) + 32'(p) * 8));
        // consumer back-pressure on some results
        hold_a = rsp_paddr;
        hold_f = rsp_fault;
        for (int k = 0; k < n_tr % 3; k++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_paddr == hold_a && rsp_fault == hold_f && !req_ready,
                "R10 result held", {31'd0, rsp_valid, rsp_paddr}, {31'd0, 1'b1, hold_a});
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset req_ready", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk(mem_rd_req == 1'b0, "R1 reset mem_rd_req", 64'(mem_rd_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 16; s++) begin
            for (int p = 0; p < 256; p++) begin
                translate(s, p, 1'b0);
                if ((p % 4) == 0 || p >= 250) translate(s, p, 1'b1);
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule